// File: doc/BRIEF.md
# Sync Activity and Source Classifier

This block watches three digital sync lines on a free-running reference clock: vertical sync, horizontal sync and the sliced sync-on-green output. It measures each line's pulses (period and high time in reference clocks) and reports, for every line, whether it is active and which polarity it has. From those bits it picks the sync source with a fixed first-match priority. When that source is a composite one, it raises a confirmation flag if the pulse train is steady.

The sync-on-green line needs stronger evidence than the other two. Green video noise and repeating picture content can look like sync pulses. The green line is therefore reported active only after a run of pulses whose period and high time each stay within a small tolerance of the previous pulse. A single pulse outside the tolerance restarts the run. Horizontal and vertical activity is simpler: any edge marks the line active. The line goes inactive when no edge arrives for the timeout period.

All outputs are plain status levels that update on every clock. There is no stream interface and no back-pressure. The inputs are taken in through a two-flop synchronizer, so they may be asynchronous to the reference clock.

Top module: `sync_activity_detector`

## Requirements
- R1: After reset every output is 0: all activity bits, all polarity bits, `src_type` and `csync_ok`.
- R2: `hsync_active` and `vsync_active` become 1 within a few clocks after any edge on their input. Each returns to 0 once its input has had no edge for 2^TO_W reference clocks (TO_W defaults to 20).
- R3: A line's polarity bit is updated at each measured pulse, where the period is measured from one rising edge to the next. The bit is 1 (active-low) exactly when twice the high time is greater than the period. At a high time of exactly half the period the bit is 0.
- R4: `sog_active` becomes 1 only after LOCK_PULSES (default 64) consecutive measured pulses whose period and high time are each within ±TOL (default 2) clocks of the pulse before. The first measured pulse after a line becomes active serves only as the reference.
- R5: One measured green pulse whose period or high time differs from the previous pulse by more than TOL clocks clears `sog_active` straight away. The run count then starts again from zero. A deviation of TOL or less has no effect.
- R6: `src_type` is chosen by checking these conditions in order and taking the first that holds:
  - H and V both active gives 1 (separate).
  - H active gives 2 (composite on HSYNC).
  - V active gives 0. A lone vertical line still takes priority over green, but it yields no usable source.
  - Green active gives 3 (SOG).
  - Otherwise the result is 0 (none).
- R7: `csync_ok` is 1 when `src_type` is 3, or when `src_type` is 2 and the HSYNC pulse train is steady (by the R4 rule) while VSYNC is not. In every other case it is 0.
- R8: Once the green line has had no edge for 2^TO_W clocks, `sog_active` and `sog_neg` are 0. A new run of R4 pulses is then needed before `sog_active` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| sog_in | input | 1 | Sliced sync-on-green, asynchronous |
| vsync_active | output | 1 | Vertical sync activity |
| hsync_active | output | 1 | Horizontal sync activity |
| sog_active | output | 1 | Green sync activity, set only after a steady run of pulses |
| vsync_neg | output | 1 | Vertical polarity, 1 = active-low |
| hsync_neg | output | 1 | Horizontal polarity, 1 = active-low |
| sog_neg | output | 1 | Green polarity, 1 = active-low |
| src_type | output | 2 | 0 none, 1 separate, 2 composite on HSYNC, 3 SOG |
| csync_ok | output | 1 | Confirms that the composite source is steady |

## Verification
Each fault in the internal state shows up at the ports within a bounded time. A wrong run counter or tolerance compare shows up on `sog_active` within one pulse of the deviating pulse, because lock is lost or kept at the first mismatch. A measurement off by one clock moves the polarity decision at the half-period boundary. It also moves the tolerance edge between deviations of 2 and 3 clocks. A fault in the idle counter shows up on an activity bit one timeout period after the line goes quiet. A fault in the priority order appears on `src_type` a few clocks after the activity bits settle.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;
  typedef enum logic [1:0] {
    SRC_NONE     = 2'd0,
    SRC_SEPARATE = 2'd1,
    SRC_CSYNC_H  = 2'd2,
    SRC_SOG      = 2'd3
  } src_type_e;

  localparam int NUM_LINES = 3;
  localparam int LINE_V    = 0;
  localparam int LINE_H    = 1;
  localparam int LINE_SOG  = 2;
endpackage

// File: rtl/sync_pulse_meter.sv
module sync_pulse_meter #(
  parameter int CNT_W = 16,
  parameter int TO_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  output logic             active_o,
  output logic             neg_o,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] high_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [TO_W-1:0]  IDLE_MAX = '1;

  logic [2:0]       sync_q;
  logic [TO_W-1:0]  idle_q;
  logic [CNT_W-1:0] per_q, hi_q;
  logic             seen_rise_q;
  logic             rise_w, edge_w, timeout_w;

  assign rise_w    = sync_q[1] & ~sync_q[2];
  assign edge_w    = sync_q[1] ^ sync_q[2];
  assign timeout_w = !edge_w && (idle_q == IDLE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      idle_q   <= '0;
      active_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], sync_i};
      if (edge_w) begin
        idle_q   <= '0;
        active_o <= 1'b1;
      end else begin
        if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
        if (timeout_w) active_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q       <= '0;
      hi_q        <= '0;
      seen_rise_q <= 1'b0;
      meas_vld_o  <= 1'b0;
      period_o    <= '0;
      high_o      <= '0;
      neg_o       <= 1'b0;
    end else begin
      meas_vld_o <= 1'b0;
      if (rise_w) begin
        if (seen_rise_q && per_q != CNT_MAX) begin
          meas_vld_o <= 1'b1;
          period_o   <= per_q;
          high_o     <= hi_q;
          neg_o      <= ({hi_q, 1'b0} > {1'b0, per_q});
        end
        per_q       <= CNT_W'(1);
        hi_q        <= CNT_W'(1);
        seen_rise_q <= 1'b1;
      end else begin
        if (per_q != CNT_MAX) per_q <= per_q + 1'b1;
        if (sync_q[1] && hi_q != CNT_MAX) hi_q <= hi_q + 1'b1;
        if (timeout_w) begin
          seen_rise_q <= 1'b0;
          neg_o       <= 1'b0;
        end
      end
    end
  end

  // R2
  edge_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> active_o);
  // R2
  quiet_keeps_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !edge_w && idle_q != IDLE_MAX) |=> active_o);
  // R3
  meas_needs_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld_o |-> active_o);
endmodule

// File: rtl/sync_lock_tracker.sv
module sync_lock_tracker #(
  parameter int CNT_W       = 16,
  parameter int TOL         = 2,
  parameter int LOCK_PULSES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             meas_vld_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] high_i,
  output logic             locked_o
);
  localparam int LK_W = $clog2(LOCK_PULSES + 1);
  localparam logic [LK_W-1:0]  LOCK_CNT = LK_W'(LOCK_PULSES);
  localparam logic [CNT_W-1:0] TOL_CNT  = CNT_W'(TOL);

  logic [CNT_W-1:0] prev_per_q, prev_hi_q;
  logic             prev_vld_q;
  logic [LK_W-1:0]  run_q;
  logic             match_w;

  function automatic logic [CNT_W-1:0] gap(input logic [CNT_W-1:0] a,
                                           input logic [CNT_W-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  assign match_w = (gap(period_i, prev_per_q) <= TOL_CNT) &&
                   (gap(high_i, prev_hi_q) <= TOL_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_per_q <= '0;
      prev_hi_q  <= '0;
      prev_vld_q <= 1'b0;
      run_q      <= '0;
    end else if (!active_i) begin
      prev_vld_q <= 1'b0;
      run_q      <= '0;
    end else if (meas_vld_i) begin
      prev_per_q <= period_i;
      prev_hi_q  <= high_i;
      prev_vld_q <= 1'b1;
      if (prev_vld_q && match_w) begin
        if (run_q != LOCK_CNT) run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end

  assign locked_o = (run_q == LOCK_CNT);

  // R5
  mismatch_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && meas_vld_i && !(prev_vld_q && match_w)) |=> !locked_o);
  // R8
  idle_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !locked_o);
  // R4
  lock_needs_reference_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> prev_vld_q);
endmodule

// File: rtl/sync_source_picker.sv
module sync_source_picker
  import sync_det_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      v_act_i,
  input  logic      h_act_i,
  input  logic [2:0] steady_i,
  output src_type_e src_o,
  output logic      csync_ok_o
);
  src_type_e pick_w;
  logic      ok_w;

  always_comb begin
    if (h_act_i && v_act_i)       pick_w = SRC_SEPARATE;
    else if (h_act_i)             pick_w = SRC_CSYNC_H;
    else if (v_act_i)             pick_w = SRC_NONE;
    else if (steady_i[LINE_SOG])  pick_w = SRC_SOG;
    else                          pick_w = SRC_NONE;
    unique case (pick_w)
      SRC_SOG:     ok_w = 1'b1;
      SRC_CSYNC_H: ok_w = steady_i[LINE_H] && !steady_i[LINE_V];
      default:     ok_w = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_o      <= SRC_NONE;
      csync_ok_o <= 1'b0;
    end else begin
      src_o      <= pick_w;
      csync_ok_o <= ok_w;
    end
  end

  // R6
  hv_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_act_i && v_act_i) |=> (src_o == SRC_SEPARATE));
  // R6
  sog_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_act_i || v_act_i) |=> (src_o != SRC_SOG));
  // R7
  csync_only_composite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csync_ok_o |-> (src_o == SRC_SOG || src_o == SRC_CSYNC_H));
endmodule

// File: rtl/sync_activity_detector.sv
module sync_activity_detector
  import sync_det_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TO_W        = 20,
  parameter int TOL         = 2,
  parameter int LOCK_PULSES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsync_in,
  input  logic       hsync_in,
  input  logic       sog_in,
  output logic       vsync_active,
  output logic       hsync_active,
  output logic       sog_active,
  output logic       vsync_neg,
  output logic       hsync_neg,
  output logic       sog_neg,
  output logic [1:0] src_type,
  output logic       csync_ok
);
  logic [NUM_LINES-1:0] line_in, act, neg, meas_vld, steady;
  logic [CNT_W-1:0]     period [NUM_LINES];
  logic [CNT_W-1:0]     high   [NUM_LINES];
  src_type_e            src_w;

  assign line_in = {sog_in, hsync_in, vsync_in};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    sync_pulse_meter #(.CNT_W(CNT_W), .TO_W(TO_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .sync_i(line_in[i]),
      .active_o(act[i]), .neg_o(neg[i]), .meas_vld_o(meas_vld[i]),
      .period_o(period[i]), .high_o(high[i])
    );
    sync_lock_tracker #(.CNT_W(CNT_W), .TOL(TOL), .LOCK_PULSES(LOCK_PULSES)) u_lock (
      .clk(clk), .rst_n(rst_n), .active_i(act[i]), .meas_vld_i(meas_vld[i]),
      .period_i(period[i]), .high_i(high[i]), .locked_o(steady[i])
    );
  end

  sync_source_picker u_pick (
    .clk(clk), .rst_n(rst_n),
    .v_act_i(act[LINE_V]), .h_act_i(act[LINE_H]),
    .steady_i(steady), .src_o(src_w), .csync_ok_o(csync_ok)
  );

  assign vsync_active = act[LINE_V];
  assign hsync_active = act[LINE_H];
  assign sog_active   = steady[LINE_SOG];
  assign vsync_neg    = neg[LINE_V];
  assign hsync_neg    = neg[LINE_H];
  assign sog_neg      = neg[LINE_SOG];
  assign src_type     = src_w;

  // R8
  sog_idle_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act[LINE_SOG] |-> !sog_neg);
endmodule

// File: tb/sync_activity_detector_test.sv
module sync_activity_detector_test;
  localparam int LOCKN = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] sig = '0;
  logic va, ha, sa, vn, hn, sn, cok;
  logic [1:0] st;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sync_activity_detector #(.CNT_W(10), .TO_W(8), .TOL(2), .LOCK_PULSES(LOCKN)) uut (
    .clk(clk), .rst_n(rst_n), .vsync_in(sig[0]), .hsync_in(sig[1]), .sog_in(sig[2]),
    .vsync_active(va), .hsync_active(ha), .sog_active(sa),
    .vsync_neg(vn), .hsync_neg(hn), .sog_neg(sn), .src_type(st), .csync_ok(cok)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int ch, input int hi, input int lo);
    sig[ch] = 1'b1; tick(hi);
    sig[ch] = 1'b0; tick(lo);
  endtask

  task automatic pulses(input int ch, input int hi, input int lo, input int n);
    for (int k = 0; k < n; k++) pulse(ch, hi, lo);
  endtask

  // pattern run for source classification; irregular variants alternate 40/60 periods
  task automatic run_mix(input bit h, input bit v, input bit s, input bit h_irr, input bit s_irr);
    for (int t = 0; t < 1000; t++) begin
      sig[1] = h && (h_irr ? ((t % 100) < 10 || ((t % 100) >= 40 && (t % 100) < 50)) : ((t % 40) < 10));
      sig[0] = v && ((t % 200) < 20);
      sig[2] = s && (s_irr ? ((t % 100) < 8 || ((t % 100) >= 40 && (t % 100) < 48)) : ((t % 40) < 8));
      tick(1);
    end
    sig = '0;
    tick(4);
  endtask

  initial begin
    fork
      begin
        tick(3);
        // R1 reset state
        check("R1 vsync_active", va, 0); check("R1 hsync_active", ha, 0);
        check("R1 sog_active", sa, 0);   check("R1 neg bits", {vn, hn, sn}, 0);
        check("R1 src_type", st, 0);     check("R1 csync_ok", cok, 0);
        rst_n = 1'b1;
        tick(3);

        // R2 activity set by edge, cleared after 256 idle clocks
        pulse(1, 10, 1); tick(4);
        check("R2 hsync_active after edge", ha, 1);
        tick(200);
        check("R2 hsync_active before timeout", ha, 1);
        tick(80);
        check("R2 hsync_active after timeout", ha, 0);
        pulse(0, 10, 5);
        check("R2 vsync_active after edge", va, 1);
        tick(300);
        check("R2 vsync_active after timeout", va, 0);

        // R3 polarity sweep, period 40
        for (int hi = 4; hi <= 36; hi++) begin
          pulses(1, hi, 40 - hi, 3);
          check($sformatf("R3 hsync_neg hi=%0d", hi), hn, (2 * hi > 40) ? 1 : 0);
        end
        pulses(2, 30, 10, 3);
        check("R3 sog_neg active-low", sn, 1);
        tick(300);
        check("R8 sog_neg cleared on idle", sn, 0);

        // R4 exact run length after idle
        pulses(2, 12, 28, LOCKN + 1);
        check("R4 not active one match short", sa, 0);
        sig[2] = 1'b1; tick(6);
        check("R4 active at run length", sa, 1);
        sig[2] = 1'b1; tick(6); sig[2] = 1'b0; tick(28);

        // R5 tolerance sweep on period and on high time
        for (int mode = 0; mode < 2; mode++) begin
          for (int d = -4; d <= 4; d++) begin
            pulses(2, 12, 28, LOCKN + 3);
            check("R4 relocked before deviation", sa, 1);
            if (mode == 0) pulse(2, 12, 28 + d);
            else           pulse(2, 12 + d, 28 - d);
            sig[2] = 1'b1; tick(6);
            check($sformatf("R5 mode=%0d d=%0d", mode, d), sa, (d >= -2 && d <= 2) ? 1 : 0);
            tick(6); sig[2] = 1'b0; tick(28);
          end
        end

        // R8 idle clears lock
        tick(300);
        check("R8 sog_active after idle", sa, 0);

        // R6/R7 exhaustive over line combinations
        for (int c = 0; c < 8; c++) begin
          bit h, v, s;
          int et, ec;
          h = c[0]; v = c[1]; s = c[2];
          run_mix(h, v, s, 1'b0, 1'b0);
          et = (h && v) ? 1 : h ? 2 : v ? 0 : s ? 3 : 0;
          ec = (et == 2 || et == 3) ? 1 : 0;
          check($sformatf("R6 src_type combo %0d", c), st, et);
          check($sformatf("R7 csync_ok combo %0d", c), cok, ec);
          check($sformatf("R2 hsync_active combo %0d", c), ha, h);
          check($sformatf("R4 sog_active combo %0d", c), sa, s);
          tick(300);
        end
        run_mix(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 irregular hsync type", st, 2);
        check("R7 irregular hsync not confirmed", cok, 0);
        tick(300);
        run_mix(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R5 irregular green rejected", sa, 0);
        check("R6 irregular green type", st, 0);
      end
      begin
        tick(150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule